// File: doc/BRIEF.md
# Internal Data Space Access Controller

This block resolves every byte and bit access that an 8-bit microcontroller core makes to its on-chip data space. In a single cycle it turns an access request into a physical target. The target is the lower RAM, the optional upper RAM, or the special-function-register (SFR) bus. The request is made by register, direct, indirect or stack addressing, or by bit address. Reads are combinational in the same cycle. Writes, including read-modify-write bit updates, take effect at the next rising clock edge.

The controller owns the internal RAM and the 8-bit stack pointer. It forms working-register addresses from the two bank-select bits that the core supplies from its status word. The SFR contents live outside the block, behind a simple bus. That bus has a combinational read and a write that is clocked on the same edge. The parameter `UPPER_RAM` chooses a 256-byte RAM (1) or a 128-byte RAM (0).

Top module: `idata_access_unit`

## Requirements
- R1: After reset the stack pointer `sp_o` reads 07h, so the first push lands at 08h.
- R2: A direct access (`mode_i`=1) to an address below 80h reads or writes the RAM byte at that address and leaves `sfr_rd_o` and `sfr_we_o` low.
- R3: A direct access to an address of 80h or above goes to the SFR bus. `sfr_addr_o` carries the address. A read raises `sfr_rd_o` and returns `sfr_rdata_i` on `rdata_o`. A write raises `sfr_we_o` with `sfr_wdata_o` = `wdata_i`.
- R4: A register access (`mode_i`=0) targets RAM byte `bank_i`*8 + `addr_i[2:0]`.
- R5: An indirect access (`mode_i`=2) uses as its target address the RAM byte `bank_i`*8 + `addr_i[0]`, which is R0 or R1 of the current bank. It never drives the SFR bus.
- R6: With `UPPER_RAM`=1, indirect and stack accesses at 80h–FFh reach an upper RAM that is separate from the SFRs at the same addresses.
- R7: With `UPPER_RAM`=0, indirect or stack writes at 80h or above are discarded, and reads there return 00h.
- R8: A push (`op_i`=2) first increments the stack pointer and then writes `wdata_i` at the new value. A pop (`op_i`=3) returns the byte at the stack pointer and then decrements it. The stack pointer wraps modulo 256.
- R9: Stack accesses are indirect. A stack above 7Fh therefore goes to upper RAM, or is discarded when no upper RAM exists, and it never drives the SFR bus.
- R10: A bit read (`op_i`=4) at bit address b < 80h returns bit b[2:0] of RAM byte 20h + b[6:3] on `bit_rdata_o`.
- R11: A bit write (`op_i`=5) replaces only bit b[2:0] of the containing byte with `bit_wdata_i`. The other seven bits keep their values.
- R12: A bit address b ≥ 80h maps to SFR byte {b[7:3],000}. A bit write there raises both `sfr_rd_o` and `sfr_we_o` in the same cycle and writes back the merged byte.
- R13: With `op_valid_i` low, the block drives no SFR strobe, `rdata_o` and `bit_rdata_o` read 0, and no RAM byte or stack pointer changes. Byte reads and writes use `op_i`=0 and 1. When no byte or bit is returned, `rdata_o` and `bit_rdata_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Access request valid this cycle |
| op_i | input | 3 | 0 read, 1 write, 2 push, 3 pop, 4 bit read, 5 bit write |
| mode_i | input | 2 | Byte addressing: 0 register, 1 direct, 2 indirect |
| addr_i | input | 8 | Direct address, or register number in [2:0] (pointer select in [0]) |
| bank_i | input | 2 | Working-register bank select |
| wdata_i | input | 8 | Byte write and push data |
| rdata_o | output | 8 | Byte read and pop data |
| bit_addr_i | input | 8 | Bit address |
| bit_wdata_i | input | 1 | Bit write value |
| bit_rdata_o | output | 1 | Bit read value (prior value on bit write) |
| sp_o | output | 8 | Current stack pointer |
| sfr_addr_o | output | 8 | SFR bus address |
| sfr_rd_o | output | 1 | SFR read strobe |
| sfr_we_o | output | 1 | SFR write strobe |
| sfr_wdata_o | output | 8 | SFR write data |
| sfr_rdata_i | input | 8 | SFR read data, combinational |

## Verification
The hardest case to reach is a stack that crosses 7Fh or wraps through FFh into the register banks. The stack pointer can only be moved one step at a time, so the bench drives a run of 252 pushes followed by 252 pops on a 256-byte and a 128-byte instance side by side. This shows the upper RAM being filled on one instance and discarded on the other. The separation between upper RAM and SFRs is brought out by loading an indirect pointer with an address in the SFR range, writing through it, and then reading the same address directly.

// File: rtl/idata_pkg.sv
package idata_pkg;
  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_PUSH = 3'd2,
    OP_POP  = 3'd3,
    OP_BRD  = 3'd4,
    OP_BWR  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    AM_REG = 2'd0,
    AM_DIR = 2'd1,
    AM_IND = 2'd2
  } am_e;

  localparam int          BYTE_W    = 8;
  localparam int          BANK_W    = 2;
  localparam logic [7:0]  SP_RESET  = 8'h07;
  localparam logic [7:0]  BIT_BASE  = 8'h20;
endpackage

// File: rtl/idata_stack_ptr.sv
module idata_stack_ptr
  import idata_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_VAL = SP_RESET
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [BYTE_W-1:0] sp_o,
  output logic [BYTE_W-1:0] sp_inc_o
);
  logic [BYTE_W-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= RESET_VAL;
    else if (push_i) sp_q <= sp_q + BYTE_W'(1);
    else if (pop_i)  sp_q <= sp_q - BYTE_W'(1);
  end

  assign sp_o     = sp_q;
  assign sp_inc_o = sp_q + BYTE_W'(1);

  a_r1_sp_reset: assert property (@(posedge clk_i) $rose(rst_ni) |-> sp_q == RESET_VAL);
  a_r8_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> sp_q == $past(sp_q) + BYTE_W'(1));
  a_r8_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> sp_q == $past(sp_q) - BYTE_W'(1));
  a_r13_sp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(sp_q));
endmodule

// File: rtl/idata_addr_gen.sv
module idata_addr_gen
  import idata_pkg::*;
#(
  parameter bit UPPER_RAM = 1'b1
) (
  input  logic              valid_i,
  input  op_e               op_i,
  input  logic [1:0]        mode_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [BYTE_W-1:0] bit_addr_i,
  input  logic [BYTE_W-1:0] sp_i,
  input  logic [BYTE_W-1:0] sp_inc_i,
  input  logic [BYTE_W-1:0] ptr_val_i,
  output logic [4:0]        ptr_addr_o,
  output logic [BYTE_W-1:0] eff_addr_o,
  output logic              ram_hit_o,
  output logic              sfr_hit_o
);
  logic tgt_ram;

  // R0/R1 of the selected bank
  assign ptr_addr_o = {bank_i, 2'b00, addr_i[0]};

  always_comb begin
    eff_addr_o = '0;
    tgt_ram    = 1'b0;
    sfr_hit_o  = 1'b0;
    if (valid_i) begin
      case (op_i)
        OP_RD, OP_WR: begin
          case (mode_i)
            AM_REG: begin
              eff_addr_o = {3'b000, bank_i, addr_i[2:0]};
              tgt_ram    = 1'b1;
            end
            AM_DIR: begin
              eff_addr_o = addr_i;
              tgt_ram    = ~addr_i[7];
              sfr_hit_o  = addr_i[7];
            end
            AM_IND: begin
              eff_addr_o = ptr_val_i;
              tgt_ram    = 1'b1;
            end
            default: ;
          endcase
        end
        OP_PUSH: begin
          eff_addr_o = sp_inc_i;
          tgt_ram    = 1'b1;
        end
        OP_POP: begin
          eff_addr_o = sp_i;
          tgt_ram    = 1'b1;
        end
        OP_BRD, OP_BWR: begin
          if (bit_addr_i[7]) begin
            eff_addr_o = {bit_addr_i[7:3], 3'b000};
            sfr_hit_o  = 1'b1;
          end else begin
            eff_addr_o = BIT_BASE + {4'b0000, bit_addr_i[6:3]};
            tgt_ram    = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // upper half only exists when configured
  assign ram_hit_o = tgt_ram && (UPPER_RAM || !eff_addr_o[7]);
endmodule

// File: rtl/idata_bit_ops.sv
module idata_bit_ops
  import idata_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [2:0]        idx_i,
  input  logic              val_i,
  output logic              bit_o,
  output logic [BYTE_W-1:0] merged_o
);
  assign bit_o = byte_i[idx_i];

  for (genvar g = 0; g < BYTE_W; g++) begin : g_merge
    assign merged_o[g] = (idx_i == 3'(g)) ? val_i : byte_i[g];
  end
endmodule

// File: rtl/idata_ram.sv
module idata_ram
  import idata_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [BYTE_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [BYTE_W-1:0] rdata_b_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/idata_access_unit.sv
module idata_access_unit
  import idata_pkg::*;
#(
  parameter bit UPPER_RAM = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       op_valid_i,
  input  logic [2:0] op_i,
  input  logic [1:0] mode_i,
  input  logic [7:0] addr_i,
  input  logic [1:0] bank_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [7:0] bit_addr_i,
  input  logic       bit_wdata_i,
  output logic       bit_rdata_o,
  output logic [7:0] sp_o,
  output logic [7:0] sfr_addr_o,
  output logic       sfr_rd_o,
  output logic       sfr_we_o,
  output logic [7:0] sfr_wdata_o,
  input  logic [7:0] sfr_rdata_i
);
  localparam int RAM_DEPTH = UPPER_RAM ? 256 : 128;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);

  op_e               op;
  logic              is_bit, is_write, is_read, byte_out;
  logic              do_push, do_pop;
  logic [BYTE_W-1:0] sp, sp_inc;
  logic [4:0]        ptr_addr;
  logic [BYTE_W-1:0] ptr_val, eff_addr, ram_rd, src_byte, merged, wr_byte;
  logic              ram_hit, sfr_hit, bit_val;

  assign op       = op_e'(op_i);
  assign is_bit   = (op == OP_BRD) || (op == OP_BWR);
  assign is_write = op_valid_i && (op == OP_WR || op == OP_PUSH || op == OP_BWR);
  assign is_read  = op_valid_i && (op == OP_RD || op == OP_POP || is_bit);
  assign byte_out = op_valid_i && (op == OP_RD || op == OP_POP);
  assign do_push  = op_valid_i && (op == OP_PUSH);
  assign do_pop   = op_valid_i && (op == OP_POP);

  idata_stack_ptr u_sp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (do_push),
    .pop_i    (do_pop),
    .sp_o     (sp),
    .sp_inc_o (sp_inc)
  );

  idata_addr_gen #(.UPPER_RAM(UPPER_RAM)) u_agen (
    .valid_i    (op_valid_i),
    .op_i       (op),
    .mode_i     (mode_i),
    .addr_i     (addr_i),
    .bank_i     (bank_i),
    .bit_addr_i (bit_addr_i),
    .sp_i       (sp),
    .sp_inc_i   (sp_inc),
    .ptr_val_i  (ptr_val),
    .ptr_addr_o (ptr_addr),
    .eff_addr_o (eff_addr),
    .ram_hit_o  (ram_hit),
    .sfr_hit_o  (sfr_hit)
  );

  idata_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk_i     (clk_i),
    .we_i      (is_write && ram_hit),
    .waddr_i   (eff_addr[RAM_AW-1:0]),
    .wdata_i   (wr_byte),
    .raddr_a_i (eff_addr[RAM_AW-1:0]),
    .rdata_a_o (ram_rd),
    .raddr_b_i (RAM_AW'(ptr_addr)),
    .rdata_b_o (ptr_val)
  );

  // absent upper RAM reads as 00h
  assign src_byte = sfr_hit ? sfr_rdata_i : (ram_hit ? ram_rd : '0);

  idata_bit_ops u_bits (
    .byte_i   (src_byte),
    .idx_i    (bit_addr_i[2:0]),
    .val_i    (bit_wdata_i),
    .bit_o    (bit_val),
    .merged_o (merged)
  );

  assign wr_byte     = is_bit ? merged : wdata_i;
  assign rdata_o     = byte_out ? src_byte : '0;
  assign bit_rdata_o = op_valid_i && is_bit && bit_val;
  assign sp_o        = sp;
  assign sfr_addr_o  = sfr_hit ? eff_addr : '0;
  assign sfr_rd_o    = is_read && sfr_hit;
  assign sfr_we_o    = is_write && sfr_hit;
  assign sfr_wdata_o = sfr_we_o ? wr_byte : '0;

  a_r5_ind_no_sfr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_i == 3'd0 || op_i == 3'd1) && mode_i == 2'd2) |-> !sfr_rd_o && !sfr_we_o);
  a_r9_stack_no_sfr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_i == 3'd2 || op_i == 3'd3)) |-> !sfr_rd_o && !sfr_we_o);
  a_r2_low_direct_no_sfr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i <= 3'd1 && mode_i == 2'd1 && !addr_i[7]) |-> !sfr_rd_o && !sfr_we_o);
  a_r12_sfr_bit_rmw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd5 && bit_addr_i[7]) |-> sfr_rd_o && sfr_we_o && sfr_addr_o[2:0] == 3'b000);
  a_r11_one_bit_changes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd5 && bit_addr_i[7]) |-> $countones(sfr_wdata_o ^ sfr_rdata_i) <= 1);
  a_r13_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> !sfr_rd_o && !sfr_we_o && rdata_o == 8'h00 && !bit_rdata_o);
endmodule

// File: tb/test_idata_access_unit.sv
module test_idata_access_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] mode = '0;
  logic [7:0] addr = '0;
  logic [1:0] bank = '0;
  logic [7:0] wdata = '0;
  logic [7:0] baddr = '0;
  logic       bval = 1'b0;

  logic [7:0] rdata_w [2];
  logic       bit_w [2];
  logic [7:0] sp_w [2];
  logic [7:0] sfr_addr_w [2];
  logic       sfr_rd_w [2];
  logic       sfr_we_w [2];
  logic [7:0] sfr_wdata_w [2];
  logic [7:0] sfr_rdata_w [2];

  logic [7:0] sfr_mem [2][256];
  logic [7:0] ref_ram [2][256];
  logic [7:0] ref_sfr [2][256];
  logic [7:0] ref_sp [2];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  idata_access_unit #(.UPPER_RAM(1'b0)) i_idata_access_unit_small (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(valid), .op_i(op), .mode_i(mode),
    .addr_i(addr), .bank_i(bank), .wdata_i(wdata), .rdata_o(rdata_w[0]),
    .bit_addr_i(baddr), .bit_wdata_i(bval), .bit_rdata_o(bit_w[0]), .sp_o(sp_w[0]),
    .sfr_addr_o(sfr_addr_w[0]), .sfr_rd_o(sfr_rd_w[0]), .sfr_we_o(sfr_we_w[0]),
    .sfr_wdata_o(sfr_wdata_w[0]), .sfr_rdata_i(sfr_rdata_w[0]));

  idata_access_unit #(.UPPER_RAM(1'b1)) i_idata_access_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(valid), .op_i(op), .mode_i(mode),
    .addr_i(addr), .bank_i(bank), .wdata_i(wdata), .rdata_o(rdata_w[1]),
    .bit_addr_i(baddr), .bit_wdata_i(bval), .bit_rdata_o(bit_w[1]), .sp_o(sp_w[1]),
    .sfr_addr_o(sfr_addr_w[1]), .sfr_rd_o(sfr_rd_w[1]), .sfr_we_o(sfr_we_w[1]),
    .sfr_wdata_o(sfr_wdata_w[1]), .sfr_rdata_i(sfr_rdata_w[1]));

  // SFR peripheral model
  always_comb begin
    for (int u = 0; u < 2; u++) sfr_rdata_w[u] = sfr_mem[u][sfr_addr_w[u]];
  end
  always @(posedge clk) begin
    for (int u = 0; u < 2; u++)
      if (sfr_we_w[u]) sfr_mem[u][sfr_addr_w[u]] <= sfr_wdata_w[u];
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what, input int u);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s unit%0d: actual %h expected %h", req, what, u, act, exp);
    end
  endtask

  // one access cycle; expected values follow the requirements
  task automatic apply(input logic v, input logic [2:0] o, input logic [1:0] m, input logic [7:0] a,
                       input logic [1:0] b, input logic [7:0] wd, input logic [7:0] ba, input logic bv,
                       input string req);
    logic [7:0] ea [2];
    bit         is_sfr [2];
    bit         present [2];
    logic [7:0] cur [2];
    logic [7:0] nb;
    bit         wr_op;
    @(negedge clk);
    valid = v; op = o; mode = m; addr = a; bank = b; wdata = wd; baddr = ba; bval = bv;
    #4;
    wr_op = v && (o == 3'd1 || o == 3'd2 || o == 3'd5);
    for (int u = 0; u < 2; u++) begin
      is_sfr[u] = 1'b0;
      present[u] = 1'b0;
      ea[u] = 8'h00;
      if (v) begin
        present[u] = 1'b1;
        case (o)
          3'd0, 3'd1: begin
            if (m == 2'd0) ea[u] = {3'b000, b, a[2:0]};
            else if (m == 2'd1) begin ea[u] = a; is_sfr[u] = a[7]; end
            else if (m == 2'd2) ea[u] = ref_ram[u][{3'b000, b, 2'b00, a[0]}];
            else present[u] = 1'b0;
          end
          3'd2: ea[u] = ref_sp[u] + 8'd1;
          3'd3: ea[u] = ref_sp[u];
          3'd4, 3'd5: begin
            if (ba[7]) begin ea[u] = {ba[7:3], 3'b000}; is_sfr[u] = 1'b1; end
            else ea[u] = 8'h20 + 8'(ba[6:3]);
          end
          default: present[u] = 1'b0;
        endcase
        if (!is_sfr[u] && u == 0 && ea[u][7]) present[u] = 1'b0;
      end
      cur[u] = !present[u] ? 8'h00 : (is_sfr[u] ? ref_sfr[u][ea[u]] : ref_ram[u][ea[u]]);
      chk(rdata_w[u], (v && (o == 3'd0 || o == 3'd3)) ? cur[u] : 8'h00, req, "rdata", u);
      chk({7'b0, bit_w[u]}, (v && (o == 3'd4 || o == 3'd5)) ? {7'b0, cur[u][ba[2:0]]} : 8'h00, req, "bit", u);
      chk({7'b0, sfr_rd_w[u]}, {7'b0, is_sfr[u] && o != 3'd1}, req, "sfr_rd", u);
      chk({7'b0, sfr_we_w[u]}, {7'b0, is_sfr[u] && wr_op}, req, "sfr_we", u);
      chk(sfr_addr_w[u], is_sfr[u] ? ea[u] : 8'h00, req, "sfr_addr", u);
      chk(sp_w[u], ref_sp[u], req, "sp", u);
    end
    @(posedge clk);
    for (int u = 0; u < 2; u++) begin
      if (wr_op && present[u]) begin
        nb = wd;
        if (o == 3'd5) begin nb = cur[u]; nb[ba[2:0]] = bv; end
        if (is_sfr[u]) ref_sfr[u][ea[u]] = nb;
        else ref_ram[u][ea[u]] = nb;
      end
      if (v && o == 3'd2) ref_sp[u] = ref_sp[u] + 8'd1;
      if (v && o == 3'd3) ref_sp[u] = ref_sp[u] - 8'd1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      ref_sp[u] = 8'h07;
      for (int i = 0; i < 256; i++) begin
        ref_ram[u][i] = 8'h00; ref_sfr[u][i] = 8'h00; sfr_mem[u][i] = 8'h00;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    for (int u = 0; u < 2; u++) chk(sp_w[u], 8'h07, "R1", "sp_reset", u);

    // R2: fill lower RAM directly
    for (int i = 0; i < 128; i++) apply(1, 3'd1, 2'd1, 8'(i), 2'd0, 8'(i) ^ 8'h5A, 8'h00, 0, "R2");
    // R6/R7: fill upper RAM through R0 of bank 0
    for (int i = 128; i < 256; i++) begin
      apply(1, 3'd1, 2'd1, 8'h00, 2'd0, 8'(i), 8'h00, 0, "R2");
      apply(1, 3'd1, 2'd2, 8'h00, 2'd0, ~8'(i), 8'h00, 0, "R6");
    end
    // R3: SFR writes and direct sweep
    for (int i = 128; i < 256; i++) apply(1, 3'd1, 2'd1, 8'(i), 2'd0, 8'(i) + 8'd3, 8'h00, 0, "R3");
    for (int i = 0; i < 256; i++) apply(1, 3'd0, 2'd1, 8'(i), 2'd0, 8'h00, 8'h00, 0, i < 128 ? "R2" : "R3");
    // R4: banked registers
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 8; r++) begin
        apply(1, 3'd1, 2'd0, 8'(r) | 8'hF8, 2'(b), 8'(b * 16 + r + 1), 8'h00, 0, "R4");
        apply(1, 3'd0, 2'd1, 8'(b * 8 + r), 2'd0, 8'h00, 8'h00, 0, "R4");
        apply(1, 3'd0, 2'd0, 8'(r), 2'(b), 8'h00, 8'h00, 0, "R4");
      end
    // R5/R6/R7: pointers in every bank, one low and one in SFR range
    for (int b = 0; b < 4; b++) begin
      apply(1, 3'd1, 2'd0, 8'h00, 2'(b), 8'h30 + 8'(b), 8'h00, 0, "R5");
      apply(1, 3'd1, 2'd0, 8'h01, 2'(b), 8'hC0 + 8'(b), 8'h00, 0, "R5");
      apply(1, 3'd0, 2'd2, 8'h00, 2'(b), 8'h00, 8'h00, 0, "R5");
      apply(1, 3'd0, 2'd2, 8'h01, 2'(b), 8'h00, 8'h00, 0, "R6");
      apply(1, 3'd1, 2'd2, 8'h01, 2'(b), 8'hE0 + 8'(b), 8'h00, 0, "R7");
      apply(1, 3'd0, 2'd2, 8'h01, 2'(b), 8'h00, 8'h00, 0, "R7");
      apply(1, 3'd0, 2'd1, 8'hC0 + 8'(b), 2'd0, 8'h00, 8'h00, 0, "R6");
      apply(1, 3'd1, 2'd2, 8'h00, 2'(b), 8'hA0 + 8'(b), 8'h00, 0, "R5");
      apply(1, 3'd0, 2'd1, 8'h30 + 8'(b), 2'd0, 8'h00, 8'h00, 0, "R5");
    end
    // R8: short push/pop
    for (int i = 0; i < 3; i++) apply(1, 3'd2, 2'd0, 8'h00, 2'd0, 8'h70 + 8'(i), 8'h00, 0, "R8");
    apply(1, 3'd0, 2'd1, 8'h08, 2'd0, 8'h00, 8'h00, 0, "R8");
    for (int i = 0; i < 3; i++) apply(1, 3'd3, 2'd0, 8'h00, 2'd0, 8'h00, 8'h00, 0, "R8");
    // R9/R8: across 7Fh and wrapping through FFh
    for (int i = 0; i < 252; i++) apply(1, 3'd2, 2'd0, 8'h00, 2'd0, 8'(i * 7 + 1), 8'h00, 0, "R9");
    for (int i = 0; i < 252; i++) apply(1, 3'd3, 2'd0, 8'h00, 2'd0, 8'h00, 8'h00, 0, i < 4 ? "R8" : "R9");
    // R10/R12: bit reads
    for (int i = 0; i < 256; i++) apply(1, 3'd4, 2'd0, 8'h00, 2'd0, 8'h00, 8'(i), 0, i < 128 ? "R10" : "R12");
    // R11/R12: bit writes, then byte read-back
    for (int i = 0; i < 256; i++) begin
      apply(1, 3'd5, 2'd0, 8'h00, 2'd0, 8'h00, 8'(i), i[0] ^ i[3] ^ i[6], i < 128 ? "R11" : "R12");
      apply(1, 3'd0, 2'd1, i < 128 ? 8'h20 + 8'(i / 8) : 8'(i & 8'hF8), 2'd0, 8'h00, 8'h00, 0, "R11");
    end
    // R13: idle cycles carrying write-like inputs
    for (int i = 0; i < 16; i++) begin
      apply(0, 3'(i % 6), 2'(i % 3), 8'(i * 17), 2'(i), 8'hFF, 8'(i * 13), 1, "R13");
      apply(1, 3'd0, 2'd1, 8'(i * 17), 2'd0, 8'h00, 8'h00, 0, "R13");
      apply(1, 3'd4, 2'd0, 8'h00, 2'd0, 8'h00, 8'(i * 13), 0, "R13");
    end
    finish_run();
  end
endmodule